// File: doc/BRIEF.md
# Flux Pulse Data Separator

This block turns a stream of flux-transition pulses, as delivered by a disk or tape read channel, into a serial bit stream. The input is a single-cycle pulse strobe plus a clock-enable tick. A phase counter advances on every tick. When the phase reaches the current window length, the bit window closes. A pulse that lands in a window that is still empty produces a 1. A window that closes with no pulse in it produces a 0.

The window length is not fixed. Every accepted pulse logs the number of ticks since the previous accepted pulse into a small circular history. Each entry also stores how many nominal bit cells that spacing represents, rounded to the nearest whole cell. Running totals of both columns are kept, and the window length becomes total spacing divided by total cells. Both divisions share one sequential restoring divider, which runs on every clock and not only on ticks. Each accepted pulse also pulls the phase halfway toward the middle of the window. Software-free operation is assumed: the nominal clocks-per-bit value is loaded through a strobe and takes effect at once.

Top module: `dpll_data_separator`

## Requirements
- R1: After reset, bitValid is low. The window length and the nominal cell length both equal the parameter NOM_RESET. Every history entry holds spacing 1 and cell count 1.
- R2: Each cycle with tick high adds one to the phase and to the spacing counter. The spacing counter saturates at 2^SPACE_W-1. When the phase (after any pulse handling in that cycle) is at least the window length, the window closes: the phase drops by the window length and the filled flag clears.
- R3: A window that closes while its filled flag is clear gives bitValid=1 with bitValue=0 in the cycle after the closing tick.
- R4: A pulse while the filled flag is clear is accepted. It gives bitValid=1 with bitValue=1 in the next cycle, sets the flag, and restarts the spacing count from zero. A window that closes with the flag set gives no output.
- R5: A pulse while the filled flag is set produces no output and changes no state.
- R6: Each accepted spacing s (including a tick in the same cycle) is written round-robin into a DEPTH-entry history, together with the cell count (s + nominal/2) / nominal. Running totals are updated by subtracting the old slot and adding the new one. The window length then becomes totalSpacing / totalCells, unless the divisor or the quotient is zero. The update is in place within 40 clock cycles of the pulse for the default parameters.
- R7: On an accepted pulse, with p the phase after that cycle's tick and W the window length, the phase becomes p - ((p - W/2 + 1) >>> 1), using floor arithmetic.
- R8: nomLoad with a nonzero nomValue sets both the nominal cell length and the window length to nomValue in the next cycle. A load of zero is ignored.
- R9: If a tick would close the window in the same cycle that a pulse arrives, the pulse is handled first against that window. The close test then uses the corrected phase, so only the 1 is reported.
- R10: Pulses that arrive while the divider is busy are still accepted and reported at once. Their history update is queued one deep, the latest spacing winning, and runs when the divider is free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable that advances phase and spacing |
| pulseIn | input | 1 | Flux transition strobe |
| nomLoad | input | 1 | Load strobe for the nominal cell length |
| nomValue | input | CPB_W | New nominal clocks per bit |
| bitValid | output | 1 | A recovered bit is present this cycle |
| bitValue | output | 1 | The recovered bit value |

## Verification
The assertions assume that reset is synchronous and that a nonzero nominal load is never overridden. They also assume the divider is only started when idle, which the control guarantees by serialising the two divisions. The exact bit-stream checks additionally assume that any window update finishes before the next tick or pulse can use it. The stimulus keeps to this by spacing ticks 56 clocks apart, placing pulses only in the tick cycle or the cycle after it, and loading a new nominal value only after a full idle gap. The one dense burst uses a history filled with identical entries, so a deferred or dropped update cannot change the window.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadPend;    // capture the spacing of a freshly accepted pulse
    logic startMult;   // divider: spacing -> cell count
    logic commitMult;  // write history slot, update totals
    logic startWin;    // divider: totals -> window length
    logic commitWin;   // take the new window length
  } dpllCtrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_MULT, ST_PREP, ST_WIN} dpllState_t;

endpackage

// File: rtl/dpll_divider.sv
module dpll_divider #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  remR, quoR, divR;
  logic [CW-1:0] cnt;
  logic          busyR, doneR;
  logic [W:0]    shifted, diff;
  logic          fits;

  always_comb begin
    shifted = {remR, quoR[W-1]};
    diff    = shifted - {1'b0, divR};
    fits    = shifted >= {1'b0, divR};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remR  <= '0;
      quoR  <= '0;
      divR  <= '0;
      cnt   <= '0;
      busyR <= 1'b0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (start) begin
        remR  <= '0;
        quoR  <= dividend;
        divR  <= divisor;
        cnt   <= CW'(W);
        busyR <= 1'b1;
      end else if (busyR) begin
        remR <= fits ? diff[W-1:0] : shifted[W-1:0];
        quoR <= {quoR[W-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busyR <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign busy     = busyR;
  assign done     = doneR;
  assign quotient = quoR;

  // R10: a new division never interrupts one in flight
  a_r10_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busyR);

endmodule

// File: rtl/dpll_ctrl.sv
module dpll_ctrl
  import dpll_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      accept,
  input  logic      divDone,
  input  logic      divBusy,
  output dpllCtrl_t strobes
);
  dpllState_t state;
  logic       pendValid;

  always_comb begin
    strobes          = '0;
    strobes.loadPend = accept;
    unique case (state)
      ST_IDLE: strobes.startMult  = pendValid;
      ST_MULT: strobes.commitMult = divDone;
      ST_PREP: strobes.startWin   = 1'b1;
      ST_WIN:  strobes.commitWin  = divDone;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pendValid <= 1'b0;
    end else begin
      pendValid <= accept | (pendValid & ~strobes.startMult);
      unique case (state)
        ST_IDLE: if (pendValid) state <= ST_MULT;
        ST_MULT: if (divDone)   state <= ST_PREP;
        ST_PREP:                state <= ST_WIN;
        ST_WIN:  if (divDone)   state <= ST_IDLE;
        default:                state <= ST_IDLE;
      endcase
    end
  end

  // R10: completions only arrive while a division is owned by the sequence
  a_r10_done_in_div: assert property (@(posedge clk) disable iff (rst)
    divDone |-> (state == ST_MULT || state == ST_WIN));

  // R10: queued updates are only launched on a free divider
  a_r10_launch_free: assert property (@(posedge clk) disable iff (rst)
    (strobes.startMult || strobes.startWin) |-> !divBusy);

endmodule

// File: rtl/dpll_datapath.sv
module dpll_datapath
  import dpll_pkg::*;
#(
  parameter int CPB_W     = 8,
  parameter int SPACE_W   = 12,
  parameter int DEPTH     = 10,
  parameter int NOM_RESET = 8,
  parameter int DW        = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pulseIn,
  input  logic             nomLoad,
  input  logic [CPB_W-1:0] nomValue,
  input  dpllCtrl_t        ctrl,
  input  logic [DW-1:0]    divQuot,
  output logic             accept,
  output logic [DW-1:0]    divA,
  output logic [DW-1:0]    divB,
  output logic             bitValid,
  output logic             bitValue
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SPACE_W-1:0] SP_MAX = '1;

  logic [DW-1:0]      phase, phaseA, phaseB, winLen;
  logic [SPACE_W-1:0] spacing, spacingA, pendSp, workSp;
  logic [CPB_W-1:0]   nomR;
  logic               filled, closeNow;
  logic [DW-1:0]      histSp [DEPTH];
  logic [DW-1:0]      histDv [DEPTH];
  logic [DW-1:0]      totSp, totDv;
  logic [PTR_W-1:0]   ptr;
  logic signed [DW+1:0] errS, corrS, phaseBs;

  always_comb begin
    phaseA   = phase + DW'(tick);
    spacingA = (tick && spacing != SP_MAX) ? spacing + 1'b1 : spacing;
    accept   = pulseIn & ~filled;
    errS     = $signed({2'b00, phaseA}) - $signed({3'b000, winLen[DW-1:1]});
    corrS    = (errS + (DW+2)'(1)) >>> 1;
    phaseBs  = $signed({2'b00, phaseA}) - corrS;
    phaseB   = accept ? phaseBs[DW-1:0] : phaseA;
    closeNow = tick & (phaseB >= winLen);
    divA     = ctrl.startWin ? totSp : DW'(pendSp) + DW'(nomR >> 1);
    divB     = ctrl.startWin ? totDv : DW'(nomR);
  end

  // bit window tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      spacing  <= '0;
      filled   <= 1'b0;
      bitValid <= 1'b0;
      bitValue <= 1'b0;
    end else begin
      bitValid <= accept | (closeNow & ~filled);
      bitValue <= accept;
      phase    <= closeNow ? phaseB - winLen : phaseB;
      filled   <= closeNow ? 1'b0 : (filled | accept);
      spacing  <= accept ? '0 : spacingA;
    end
  end

  // spacing history and running totals
  always_ff @(posedge clk) begin
    if (rst) begin
      pendSp <= '0;
      workSp <= '0;
      totSp  <= DW'(DEPTH);
      totDv  <= DW'(DEPTH);
      ptr    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        histSp[i] <= DW'(1);
        histDv[i] <= DW'(1);
      end
    end else begin
      if (ctrl.loadPend)  pendSp <= spacingA;
      if (ctrl.startMult) workSp <= pendSp;
      if (ctrl.commitMult) begin
        totSp       <= totSp - histSp[ptr] + DW'(workSp);
        totDv       <= totDv - histDv[ptr] + divQuot;
        histSp[ptr] <= DW'(workSp);
        histDv[ptr] <= divQuot;
        ptr         <= (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  // window length and nominal cell length
  always_ff @(posedge clk) begin
    if (rst) begin
      nomR   <= CPB_W'(NOM_RESET);
      winLen <= DW'(NOM_RESET);
    end else if (nomLoad && nomValue != '0) begin
      nomR   <= nomValue;
      winLen <= DW'(nomValue);
    end else if (ctrl.commitWin && totDv != '0 && divQuot != '0) begin
      winLen <= divQuot;
    end
  end

  // R4: a reported 1 always follows a pulse
  a_r4_one_from_pulse: assert property (@(posedge clk) disable iff (rst)
    (bitValid && bitValue) |-> $past(pulseIn));

  // R3: a reported 0 always follows a tick
  a_r3_zero_from_tick: assert property (@(posedge clk) disable iff (rst)
    (bitValid && !bitValue) |-> $past(tick));

  // R5: a pulse into a filled window yields no 1
  a_r5_filled_ignores: assert property (@(posedge clk) disable iff (rst)
    (pulseIn && filled) |=> !(bitValid && bitValue));

  // R6: cell counts never exceed spacings, so the totals keep that order
  a_r6_totals_order: assert property (@(posedge clk) disable iff (rst)
    totDv <= totSp);

  // R6: the zero guards keep the window open
  a_r6_window_nonzero: assert property (@(posedge clk) disable iff (rst)
    winLen != '0);

  // R8: a nonzero load lands in the window length
  a_r8_nominal_load: assert property (@(posedge clk) disable iff (rst)
    (nomLoad && nomValue != '0) |=> winLen == DW'($past(nomValue)));

endmodule

// File: rtl/dpll_data_separator.sv
module dpll_data_separator
  import dpll_pkg::*;
#(
  parameter int CPB_W     = 8,
  parameter int SPACE_W   = 12,
  parameter int DEPTH     = 10,
  parameter int NOM_RESET = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pulseIn,
  input  logic             nomLoad,
  input  logic [CPB_W-1:0] nomValue,
  output logic             bitValid,
  output logic             bitValue
);
  localparam int DW = SPACE_W + $clog2(DEPTH) + 1;

  dpllCtrl_t     strobes;
  logic          accept, divBusy, divDone;
  logic [DW-1:0] divA, divB, divQuot;

  dpll_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .divDone (divDone),
    .divBusy (divBusy),
    .strobes (strobes)
  );

  dpll_datapath #(
    .CPB_W     (CPB_W),
    .SPACE_W   (SPACE_W),
    .DEPTH     (DEPTH),
    .NOM_RESET (NOM_RESET),
    .DW        (DW)
  ) u_data (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .pulseIn  (pulseIn),
    .nomLoad  (nomLoad),
    .nomValue (nomValue),
    .ctrl     (strobes),
    .divQuot  (divQuot),
    .accept   (accept),
    .divA     (divA),
    .divB     (divB),
    .bitValid (bitValid),
    .bitValue (bitValue)
  );

  dpll_divider #(.W(DW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (strobes.startMult | strobes.startWin),
    .dividend (divA),
    .divisor  (divB),
    .busy     (divBusy),
    .done     (divDone),
    .quotient (divQuot)
  );

endmodule

// File: tb/tb_dpll_data_separator.sv
module tb_dpll_data_separator;
  localparam int G      = 56;     // clocks per tick slot
  localparam int DEPTH  = 10;
  localparam int SP_MAX = 4095;

  logic clk = 1'b0;
  always #10 clk = ~clk;           // 50 MHz

  logic       rst, tick, pulseIn, nomLoad;
  logic [7:0] nomValue;
  logic       bitValid, bitValue;

  dpll_data_separator dut (
    .clk(clk), .rst(rst), .tick(tick), .pulseIn(pulseIn),
    .nomLoad(nomLoad), .nomValue(nomValue),
    .bitValid(bitValid), .bitValue(bitValue)
  );

  int    checks = 0, fails = 0;
  string curReq = "R1";

  // reference state
  int mPhase, mSp, mFilled, mWin, mNom, mTS, mTD, mPtr;
  int hs [DEPTH];
  int hd [DEPTH];

  function void modelInit();
    mPhase = 0; mSp = 0; mFilled = 0; mWin = 8; mNom = 8;
    mTS = DEPTH; mTD = DEPTH; mPtr = 0;
    for (int i = 0; i < DEPTH; i++) begin hs[i] = 1; hd[i] = 1; end
  endfunction

  function void modelStep(input bit t, input bit p, input bit ld, input int nv,
                          output bit ev, output bit eb);
    int pA, sA, pB, err, mult, q;
    bit acc, cls;
    pA = mPhase + (t ? 1 : 0);
    sA = (t && mSp < SP_MAX) ? mSp + 1 : mSp;
    acc = p && (mFilled == 0);
    pB = pA;
    if (acc) begin
      err = pA - mWin / 2;                  // R7
      pB  = pA - ((err + 1) >>> 1);
    end
    cls = t && (pB >= mWin);                // R2, R9
    ev = acc || (cls && mFilled == 0);
    eb = acc;
    mFilled = cls ? 0 : ((mFilled != 0 || acc) ? 1 : 0);
    mPhase  = cls ? pB - mWin : pB;
    mSp     = acc ? 0 : sA;
    if (acc) begin                          // R6
      mult = (sA + mNom / 2) / mNom;
      mTS  = mTS - hs[mPtr] + sA;
      mTD  = mTD - hd[mPtr] + mult;
      hs[mPtr] = sA; hd[mPtr] = mult;
      mPtr = (mPtr + 1) % DEPTH;
      if (mTD != 0) begin
        q = mTS / mTD;
        if (q != 0) mWin = q;
      end
    end
    if (ld && nv != 0) begin mNom = nv; mWin = nv; end  // R8
  endfunction

  task automatic cyc(input bit t, input bit p, input bit ld = 1'b0, input int nv = 0);
    bit ev, eb;
    @(negedge clk);
    tick = t; pulseIn = p; nomLoad = ld; nomValue = nv[7:0];
    modelStep(t, p, ld, nv, ev, eb);
    @(posedge clk);
    #1;
    checks++;
    if (bitValid !== ev || (ev && bitValue !== eb)) begin
      fails++;
      $display("FAIL %s: bitValid/bitValue = %0b/%0b, expected %0b/%0b",
               curReq, bitValid, bitValue, ev, eb);
    end
  endtask

  task automatic slot(input bit p0, input bit p1);
    cyc(1'b1, p0);
    cyc(1'b0, p1);
    repeat (G - 2) cyc(1'b0, 1'b0);
  endtask

  task automatic loadNom(input int v);
    repeat (G) cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, v);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst = 1'b1; tick = 1'b0; pulseIn = 1'b0; nomLoad = 1'b0; nomValue = '0;
    modelInit();
    repeat (4) @(posedge clk);
    #1;
    // R1: no output while held in reset
    checks++;
    if (bitValid !== 1'b0) begin
      fails++;
      $display("FAIL R1: bitValid = %0b, expected 0", bitValid);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1: reset window of NOM_RESET ticks gives the first 0 on the 8th tick
    curReq = "R1";
    repeat (8) slot(1'b0, 1'b0);
    // R3: empty windows keep producing zeros
    curReq = "R3";
    repeat (24) slot(1'b0, 1'b0);

    // R8: load a shorter cell, then check a zero load is ignored
    curReq = "R8";
    loadNom(4);
    repeat (8) slot(1'b0, 1'b0);
    loadNom(0);
    repeat (8) slot(1'b0, 1'b0);

    // R5: second pulse in the same window is dropped
    curReq = "R5";
    for (int i = 0; i < 6; i++) begin
      slot(1'b1, 1'b1);
      repeat (3) slot(1'b0, 1'b0);
    end

    // R4: steady pulses at the nominal rate (also fills the history with 4/1)
    curReq = "R4";
    for (int i = 0; i < 12; i++) begin
      slot(1'b1, 1'b0);
      repeat (3) slot(1'b0, 1'b0);
    end

    // R10: dense burst, updates collide with a busy divider
    curReq = "R10";
    for (int i = 0; i < 30; i++)
      for (int j = 0; j < 4; j++) cyc(1'b1, j == 0);
    repeat (G) cyc(1'b0, 1'b0);

    // R9: pulse on exactly the tick that would close an empty window
    curReq = "R9";
    loadNom(4);
    for (int i = 0; i < 3; i++) begin
      while (mPhase + 1 < mWin) slot(1'b0, 1'b0);
      slot(1'b1, 1'b0);
    end

    // R2 R6 R7: sweep nominal length and pulse period
    curReq = "R2/R6/R7";
    for (int nom = 2; nom <= 6; nom++) begin
      loadNom(nom);
      for (int per = 1; per <= 8; per++)
        for (int k = 0; k < 8; k++) begin
          slot(k % 2 == 0, k % 2 == 1);
          repeat (per - 1) slot(1'b0, 1'b0);
        end
    end

    // R6 R7 R9: pseudo-random pulse pattern with changing nominal length
    curReq = "R6/R7/R9";
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      if (i % 100 == 0) loadNom(3 + i / 100);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      slot(lfsr[1:0] == 2'b00, lfsr[3:2] == 2'b00);
    end

    summary();
    $finish;
  end

endmodule